// File: doc/BRIEF.md
# Descriptor Ring Queue Engine

This block serves one endpoint direction of a device controller. It follows a chain of 16-byte transfer descriptors held in system memory. Each descriptor is read one 32-bit word at a time through a simple request/acknowledge memory port. When hardware owns the descriptor, the block passes the buffer address and length to an external data mover and waits for the mover to report a byte count. It then writes that count back into the descriptor and hands the descriptor back to software by clearing its ownership flag. After that it moves to the descriptor named by the next pointer.

Software controls the queue with start, stop and resume command pulses and a start address. It watches an active flag and the address of the current descriptor. A mode input picks one of two descriptor field layouts: legacy or extended. A direction input picks transmit or receive, which decides where the length and the address nibbles sit. If the engine meets a descriptor it does not own, it parks on it until software resumes the queue. A legacy transmit descriptor with zero length is reported as a length error instead of being sent.

Top module: `dq_engine`

## Requirements
- R1: After reset q_active is 0, cur_addr is 0, and mem_req, mv_req, done_o and len_err_o are all 0. While q_active is 0, no memory or mover request is made.
- R2: A cmd_start while idle loads start_addr into cur_addr with its low 4 bits forced to 0, raises q_active, and reads descriptor words 0..3 at cur_addr+0, +4, +8, +12. A cmd_start while q_active is 1 has no effect.
- R3: If word 0 bit 0 (hardware owns) reads as 0, the engine makes no further access and no mover request for that descriptor. q_active stays 1 and cur_addr keeps pointing at the descriptor.
- R4: For an owned descriptor, mv_addr is {upper nibble, word 1} and mv_len is the length field. The nibbles come from word 0 for transmit and from word 3 for receive: buffer nibble at bits [19:16] and next nibble at [23:20] in legacy mode, [27:24] and [31:28] in extended mode. The length field is word 3 [15:0] (legacy) or [19:0] (extended) for transmit, and word 0 [31:16] (legacy) or [31:12] (extended) for receive.
- R5: After the mover reports mv_count, the engine writes word 3 with its length field ([15:0] legacy, [19:0] extended) replaced by the count and all other bits kept. It then writes word 0 with bit 0 cleared and all other bits kept. The word 0 write is always the last write for a descriptor. cur_addr then becomes {next nibble, word 2} with the low 4 bits zeroed.
- R6: done_o pulses for one cycle after the word-0 write of a descriptor whose word 0 bit 7 is set, and never otherwise.
- R7: A descriptor with word 0 bit 2 (bypass) set makes no mover request and gets no word-3 write. Only word 0 is written back, with bit 0 cleared, and the engine advances to the next pointer.
- R8: In legacy transmit mode, a non-bypass descriptor whose word 3 [15:0] is 0 makes no mover request. Instead it pulses len_err_o once, and the engine parks on that descriptor with ownership kept. In extended mode a zero length goes to the mover. mv_zlp carries word 0 bit 6 in extended mode and word 3 bit 29 in legacy mode.
- R9: A cmd_stop while q_active is 1 lets the current descriptor finish. q_active then falls after that descriptor's word-0 write. If the engine is parked, q_active falls at once.
- R10: A cmd_resume while parked re-reads the descriptor at cur_addr. A cmd_resume while idle raises q_active and reads at cur_addr without reloading the start address. A cmd_resume while busy is ignored.
- R11: cur_addr [3:0] is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ext | input | 1 | 1 selects the extended field layout, 0 the legacy layout |
| dir_rx | input | 1 | 1 for receive descriptors, 0 for transmit |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| cmd_resume | input | 1 | Resume command pulse |
| start_addr | input | 36 | Address of the first descriptor |
| q_active | output | 1 | Queue active flag |
| cur_addr | output | 36 | Address of the current descriptor |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | 1 for a write access |
| mem_addr | output | 36 | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle access acknowledge |
| mv_req | output | 1 | Transfer request to the data mover, held until mv_done |
| mv_addr | output | 36 | Buffer address for the transfer |
| mv_len | output | 20 | Transfer length or receive buffer size |
| mv_zlp | output | 1 | Zero-length-packet flag of the descriptor |
| mv_done | input | 1 | One-cycle transfer completion |
| mv_count | input | 20 | Bytes actually transferred, valid with mv_done |
| done_o | output | 1 | Completion pulse for descriptors that request it |
| len_err_o | output | 1 | Length-error pulse for a zero-length legacy transmit descriptor |

## Verification
The assertions check these rules on every cycle:
- cur_addr stays 16-byte aligned.
- An idle queue is silent.
- The memory and mover requests never overlap.
- A word-3 write is always followed directly by a word-0 write that clears ownership.
- Every done pulse comes right after such a release.
- cur_addr moves only on a release, so a parked queue holds its place.
- A length error occurs only in legacy transmit mode.

Some behaviour can only be shown by the bench scenarios, because it depends on memory contents that the checks cannot see:
- the exact field placement in both layouts and both directions;
- that bits around the length field are kept;
- bypass skipping;
- parking and resuming around a ring wrap;
- stop taking effect only after the current descriptor.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam int WORD_W  = 32;
  localparam int LEN_W   = 20;
  localparam int LO_W    = 32;
  localparam int HI_W    = 4;
  localparam int ADDR_W  = LO_W + HI_W;
  localparam int ALIGN_W = 4;

  localparam int F_HWO     = 0;
  localparam int F_BYP     = 2;
  localparam int F_ZLP_EXT = 6;
  localparam int F_IOC     = 7;
  localparam int F_ZLP_LEG = 29;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_DEC, S_XFER, S_WR3, S_WR0, S_PARK
  } st_t;

  // transmit data length held in word 3
  function automatic logic [LEN_W-1:0] data_len(input logic [WORD_W-1:0] w, input logic ext);
    return ext ? w[LEN_W-1:0] : {4'h0, w[15:0]};
  endfunction

  // receive buffer size held in word 0
  function automatic logic [LEN_W-1:0] rx_limit(input logic [WORD_W-1:0] w, input logic ext);
    return ext ? w[31:12] : {4'h0, w[31:16]};
  endfunction

  function automatic logic [HI_W-1:0] buf_hi(input logic [WORD_W-1:0] w, input logic ext);
    return ext ? w[27:24] : w[19:16];
  endfunction

  function automatic logic [HI_W-1:0] nxt_hi(input logic [WORD_W-1:0] w, input logic ext);
    return ext ? w[31:28] : w[23:20];
  endfunction

  function automatic logic [ADDR_W-1:0] align16(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
  endfunction

  function automatic logic [WORD_W-1:0] put_len(input logic [WORD_W-1:0] w3,
                                                input logic [LEN_W-1:0] len, input logic ext);
    return ext ? {w3[31:LEN_W], len} : {w3[31:16], len[15:0]};
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base, input logic [3:0] i);
    return base + ADDR_W'({i, 2'b00});
  endfunction
endpackage

// File: rtl/dq_decode.sv
module dq_decode
  import dq_pkg::*;
(
  input  logic [WORD_W-1:0] w0,
  input  logic [WORD_W-1:0] w1,
  input  logic [WORD_W-1:0] w2,
  input  logic [WORD_W-1:0] w3,
  input  logic              ext,
  input  logic              rx,
  output logic              bypass,
  output logic              ioc,
  output logic              zlp,
  output logic              len_err,
  output logic [LEN_W-1:0]  xfer_len,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [ADDR_W-1:0] next_addr
);
  logic [WORD_W-1:0] nib_src;
  logic              unused_bits;

  assign nib_src   = rx ? w3 : w0;
  assign bypass    = w0[F_BYP];
  assign ioc       = w0[F_IOC];
  assign zlp       = ext ? w0[F_ZLP_EXT] : w3[F_ZLP_LEG];
  assign xfer_len  = rx ? rx_limit(w0, ext) : data_len(w3, ext);
  assign len_err   = !ext && !rx && (data_len(w3, ext) == '0);
  assign buf_addr  = {buf_hi(nib_src, ext), w1};
  assign next_addr = align16({nxt_hi(nib_src, ext), w2});
  assign unused_bits = ^{w0[11:8], w0[5:3], w0[1], w0[F_HWO]};
endmodule

// File: rtl/dq_wb.sv
module dq_wb
  import dq_pkg::*;
(
  input  logic [WORD_W-1:0] w0,
  input  logic [WORD_W-1:0] w3,
  input  logic [LEN_W-1:0]  actual,
  input  logic              ext,
  output logic [WORD_W-1:0] wb_w0,
  output logic [WORD_W-1:0] wb_w3
);
  assign wb_w0 = w0 & ~(WORD_W'(1) << F_HWO);
  assign wb_w3 = put_len(w3, actual, ext);
endmodule

// File: rtl/dq_engine.sv
module dq_engine
  import dq_pkg::*;
#(
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ext,
  input  logic              dir_rx,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_resume,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              q_active,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              mv_req,
  output logic [ADDR_W-1:0] mv_addr,
  output logic [LEN_W-1:0]  mv_len,
  output logic              mv_zlp,
  input  logic              mv_done,
  input  logic [LEN_W-1:0]  mv_count,
  output logic              done_o,
  output logic              len_err_o
);
  localparam int WORDS = DESC_BYTES / (WORD_W / 8);
  localparam int IDX_W = $clog2(WORDS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

  st_t               st;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] w [WORDS];
  logic [ADDR_W-1:0] cur_q;
  logic [LEN_W-1:0]  act_q;
  logic              stop_pend, done_q, lerr_q;

  logic              d_bypass, d_ioc, d_zlp, d_lenerr;
  logic [LEN_W-1:0]  d_len;
  logic [ADDR_W-1:0] d_buf, d_next;
  logic [WORD_W-1:0] wb_w0, wb_w3;

  // named internal events
  logic evt_unowned, evt_release, evt_fetched;
  assign evt_unowned = (st == S_RD) && mem_ack && (idx == '0) && !mem_rdata[F_HWO];
  assign evt_fetched = (st == S_RD) && mem_ack && (idx == LAST);
  assign evt_release = (st == S_WR0) && mem_ack;

  dq_decode dec_i (
    .w0(w[0]), .w1(w[1]), .w2(w[2]), .w3(w[WORDS-1]),
    .ext(mode_ext), .rx(dir_rx),
    .bypass(d_bypass), .ioc(d_ioc), .zlp(d_zlp), .len_err(d_lenerr),
    .xfer_len(d_len), .buf_addr(d_buf), .next_addr(d_next)
  );

  dq_wb wb_i (
    .w0(w[0]), .w3(w[WORDS-1]), .actual(act_q), .ext(mode_ext),
    .wb_w0(wb_w0), .wb_w3(wb_w3)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      cur_q     <= '0;
      act_q     <= '0;
      stop_pend <= 1'b0;
      done_q    <= 1'b0;
      lerr_q    <= 1'b0;
      for (int i = 0; i < WORDS; i++) w[i] <= '0;
    end else begin
      done_q <= 1'b0;
      lerr_q <= 1'b0;
      if (cmd_stop && st != S_IDLE) stop_pend <= 1'b1;
      case (st)
        S_IDLE: begin
          stop_pend <= 1'b0;
          if (cmd_start) begin
            cur_q <= align16(start_addr);
            idx   <= '0;
            st    <= S_RD;
          end else if (cmd_resume) begin
            idx <= '0;
            st  <= S_RD;
          end
        end
        S_RD: if (mem_ack) begin
          w[idx] <= mem_rdata;
          if (evt_unowned)      st  <= S_PARK;
          else if (evt_fetched) st  <= S_DEC;
          else                  idx <= idx + 1'b1;
        end
        S_DEC: begin
          if (d_bypass)      st <= S_WR0;
          else if (d_lenerr) begin lerr_q <= 1'b1; st <= S_PARK; end
          else               st <= S_XFER;
        end
        S_XFER: if (mv_done) begin
          act_q <= mv_count;
          st    <= S_WR3;
        end
        S_WR3: if (mem_ack) st <= S_WR0;
        S_WR0: if (evt_release) begin
          cur_q  <= d_next;
          done_q <= d_ioc;
          idx    <= '0;
          st     <= (stop_pend || cmd_stop) ? S_IDLE : S_RD;
        end
        S_PARK: begin
          if (stop_pend || cmd_stop) st <= S_IDLE;
          else if (cmd_resume) begin
            idx <= '0;
            st  <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign q_active  = (st != S_IDLE);
  assign cur_addr  = cur_q;
  assign mem_req   = (st == S_RD) || (st == S_WR3) || (st == S_WR0);
  assign mem_we    = (st == S_WR3) || (st == S_WR0);
  assign mem_addr  = (st == S_RD)  ? word_addr(cur_q, 4'(idx)) :
                     (st == S_WR3) ? word_addr(cur_q, 4'(LAST)) : cur_q;
  assign mem_wdata = (st == S_WR3) ? wb_w3 : wb_w0;
  assign mv_req    = (st == S_XFER);
  assign mv_addr   = d_buf;
  assign mv_len    = d_len;
  assign mv_zlp    = d_zlp;
  assign done_o    = done_q;
  assign len_err_o = lerr_q;
endmodule

// File: rtl/dq_engine_chk.sv
module dq_engine_chk
  import dq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mode_ext,
  input logic              dir_rx,
  input logic              cmd_start,
  input logic              q_active,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [3:0]        mem_lo,
  input logic              wdata_hwo,
  input logic              mem_ack,
  input logic              mv_req,
  input logic              done_o,
  input logic              len_err_o,
  input logic              evt_unowned
);
  logic rel_now, w3_now;
  assign rel_now = mem_req && mem_we && mem_ack && (mem_lo == 4'h0);
  assign w3_now  = mem_req && mem_we && mem_ack && (mem_lo == 4'hC);

  p_cur_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cur_addr[3:0] == 4'h0);
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !q_active |-> (!mem_req && !mv_req));
  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mv_req));
  p_wb_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    w3_now |=> (mem_req && mem_we && mem_lo == 4'h0));
  p_hwo_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_lo == 4'h0) |-> !wdata_hwo);
  p_done_after_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(rel_now));
  p_lenerr_legacy_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    len_err_o |-> (!mode_ext && !dir_rx));
  p_cur_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_active && !rel_now) |=> $stable(cur_addr));
  p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_active && cmd_start && !rel_now) |=> (cur_addr == $past(cur_addr)));
  p_park_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_unowned |=> (!mem_req && !mv_req));
endmodule

bind dq_engine dq_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .dir_rx(dir_rx),
  .cmd_start(cmd_start), .q_active(q_active), .cur_addr(cur_addr),
  .mem_req(mem_req), .mem_we(mem_we), .mem_lo(mem_addr[3:0]),
  .wdata_hwo(mem_wdata[0]), .mem_ack(mem_ack), .mv_req(mv_req),
  .done_o(done_o), .len_err_o(len_err_o), .evt_unowned(evt_unowned)
);

// File: tb/dq_engine_tb_top.sv
module dq_engine_tb_top;
  import dq_pkg::*;

  localparam logic [ADDR_W-1:0] BASE = 36'h100;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, mode_ext, dir_rx, cmd_start, cmd_stop, cmd_resume;
  logic [ADDR_W-1:0] start_addr;
  logic q_active, mem_req, mem_we, mv_req, mv_zlp, done_o, len_err_o;
  logic [ADDR_W-1:0] cur_addr, mem_addr, mv_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic mem_ack, mv_done;
  logic [LEN_W-1:0] mv_len, mv_count;

  dq_engine dut_i (.*);

  logic [31:0] mem [256];
  int checks = 0, fails = 0;
  int wr_n = 0, mv_n = 0, done_n = 0, lerr_n = 0;
  logic [11:0] wr_log [64];
  logic [ADDR_W-1:0] mvl_addr [16];
  logic [19:0] mvl_len [16];
  logic mvl_zlp [16];

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // memory model
  initial begin
    mem_ack = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (mem_we) begin
          mem[mem_addr[9:2]] = mem_wdata;
          if (wr_n < 64) wr_log[wr_n] = mem_addr[11:0];
          wr_n++;
        end else mem_rdata = mem[mem_addr[9:2]];
        mem_ack = 1'b1;
      end
    end
  end

  function automatic logic [19:0] exp_actual(input logic [19:0] ln, input bit rx);
    return rx ? ln - (ln >> 2) : ln;
  endfunction

  // data mover model
  initial begin
    mv_done = 1'b0; mv_count = '0;
    forever begin
      @(negedge clk);
      if (mv_done) mv_done = 1'b0;
      else if (mv_req) begin
        if (mv_n < 16) begin
          mvl_addr[mv_n] = mv_addr; mvl_len[mv_n] = mv_len; mvl_zlp[mv_n] = mv_zlp;
        end
        mv_n++;
        mv_count = exp_actual(mv_len, dir_rx);
        mv_done = 1'b1;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (done_o) done_n++;
    if (len_err_o) lerr_n++;
  end

  function automatic logic [31:0] mk_w0(bit ext, bit rx, logic [19:0] ln, logic [3:0] bn, logic [7:0] fl);
    if (rx) return ext ? {ln, 4'h0, fl} : {ln[15:0], 8'h00, fl};
    return ext ? {4'h0, bn, 16'h0, fl} : {12'h0, bn, 8'h0, fl};
  endfunction

  function automatic logic [31:0] mk_w3(bit ext, bit rx, logic [19:0] ln, logic [3:0] bn, bit zl);
    if (rx) return ext ? {4'h0, bn, 4'h0, 20'h5} : {12'h0, bn, 16'h5};
    return ext ? {12'h0, ln} : {2'b00, zl, 13'h0, ln[15:0]};
  endfunction

  function automatic logic [31:0] exp_w3(logic [31:0] w3o, logic [19:0] act, bit ext);
    return ext ? {w3o[31:20], act} : {w3o[31:16], act[15:0]};
  endfunction

  function automatic logic [ADDR_W-1:0] slot(int k);
    return BASE + ADDR_W'(16 * k);
  endfunction

  task automatic cmd(input int which);
    @(negedge clk);
    if (which == 0) cmd_start = 1'b1; else if (which == 1) cmd_stop = 1'b1; else cmd_resume = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0; cmd_stop = 1'b0; cmd_resume = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    for (int c = 0; c < 3000 && q < 6; c++) begin
      @(negedge clk);
      if (!mem_req && !mv_req) q++; else q = 0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic clr_logs();
    @(negedge clk);
    wr_n = 0; mv_n = 0; done_n = 0; lerr_n = 0;
  endtask

  task automatic stop_check(input string tag);
    cmd(1);
    wait_quiet();
    chk(tag, "active after stop", q_active, 0);
  endtask

  // n owned descriptors followed by one unowned; leaves the queue parked
  task automatic run_chain(input bit ext, input bit rx, input int n, input bit allow_byp);
    logic [31:0] w0o [5], w1o [5], w3o [5];
    logic [19:0] ln [5];
    logic [3:0] bn [5];
    bit byp [5], ioc [5], zl [5], zx [5];
    int exp_mv = 0, exp_done = 0, m = 0, wi = 0;
    logic [19:0] mask;
    mask = ext ? 20'hFFFFF : 20'h0FFFF;
    @(negedge clk);
    mode_ext = ext; dir_rx = rx;
    for (int k = 0; k < n; k++) begin
      ln[k] = 20'($urandom) & mask;
      if (ln[k] == 0) ln[k] = 20'd1;
      bn[k] = 4'($urandom);
      byp[k] = allow_byp && ($urandom % 4 == 0);
      ioc[k] = $urandom % 2;
      zl[k] = $urandom % 2;
      zx[k] = $urandom % 2;
      w0o[k] = mk_w0(ext, rx, ln[k], bn[k], {ioc[k], zx[k], 3'b000, byp[k], 1'b0, 1'b1});
      w1o[k] = $urandom;
      w3o[k] = mk_w3(ext, rx, ln[k], bn[k], zl[k]);
      mem[slot(k)[9:2]]     = w0o[k];
      mem[slot(k)[9:2] + 1] = w1o[k];
      mem[slot(k)[9:2] + 2] = 32'(slot(k + 1));
      mem[slot(k)[9:2] + 3] = w3o[k];
      if (!byp[k]) exp_mv++;
      if (ioc[k]) exp_done++;
    end
    mem[slot(n)[9:2]] = 32'h0;
    clr_logs();
    start_addr = BASE | 36'h7;
    cmd(0);
    wait_quiet();
    chk("R3", "parked active", q_active, 1);
    chk("R3", "parked cur_addr", cur_addr, slot(n));
    chk("R4", "mover calls", mv_n, exp_mv);
    chk("R6", "done pulses", done_n, exp_done);
    for (int k = 0; k < n; k++) begin
      if (!byp[k]) begin
        chk("R4", "mover addr", mvl_addr[m], {bn[k], w1o[k]});
        chk("R4", "mover len", mvl_len[m], ln[k]);
        chk("R8", "mover zlp", mvl_zlp[m], ext ? zx[k] : (rx ? 1'b0 : zl[k]));
        chk("R5", "word3 writeback", mem[slot(k)[9:2] + 3], exp_w3(w3o[k], exp_actual(ln[k], rx), ext));
        chk("R5", "write order w3", wr_log[wi], slot(k)[11:0] + 12'hC);
        wi++; m++;
      end else
        chk("R7", "bypass keeps word3", mem[slot(k)[9:2] + 3], w3o[k]);
      chk("R5", "word0 release", mem[slot(k)[9:2]], w0o[k] & ~32'h1);
      chk("R5", "write order w0", wr_log[wi], slot(k)[11:0]);
      wi++;
    end
    chk("R5", "write count", wr_n, wi);
  endtask

  initial begin
    int mv0;
    void'($urandom(32'h5EED_0125));
    rst_n = 1'b0; mode_ext = 1'b0; dir_rx = 1'b0;
    cmd_start = 1'b0; cmd_stop = 1'b0; cmd_resume = 1'b0; start_addr = '0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset active", q_active, 0);
    chk("R1", "reset cur_addr", cur_addr, 0);
    chk("R1", "reset requests", {mem_req, mv_req, done_o, len_err_o}, 0);

    // legacy transmit chain, then start while active, ring wrap via resume
    run_chain(1'b0, 1'b0, 3, 1'b0);
    chk("R11", "aligned start", cur_addr[3:0], 0);
    mv0 = mv_n;
    start_addr = 36'h200;
    cmd(0);
    wait_quiet();
    chk("R2", "start while active cur", cur_addr, slot(3));
    chk("R2", "start while active mover", mv_n, mv0);
    @(negedge clk);
    mem[slot(3)[9:2]]     = mk_w0(1'b0, 1'b0, 20'h40, 4'h3, 8'h01);
    mem[slot(3)[9:2] + 2] = 32'(BASE);
    mem[slot(3)[9:2] + 3] = mk_w3(1'b0, 1'b0, 20'h40, 4'h3, 1'b0);
    cmd(2);
    wait_quiet();
    chk("R10", "resume from park mover", mv_n, mv0 + 1);
    chk("R10", "resume wraps to ring start", cur_addr, BASE);
    chk("R3", "parked on released slot", q_active, 1);
    stop_check("R9");
    cmd(2);
    wait_quiet();
    chk("R10", "resume from idle active", q_active, 1);
    chk("R10", "resume from idle cur", cur_addr, BASE);
    stop_check("R9");

    // stop mid-chain: the first descriptor completes, then the queue goes idle
    run_chain(1'b0, 1'b0, 2, 1'b0);
    stop_check("R9");
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      mem[slot(k)[9:2]]     = mk_w0(1'b0, 1'b0, 20'h10, 4'h0, 8'h01);
      mem[slot(k)[9:2] + 2] = 32'(slot(k + 1));
      mem[slot(k)[9:2] + 3] = mk_w3(1'b0, 1'b0, 20'h10, 4'h0, 1'b0);
    end
    mem[slot(3)[9:2]] = 32'h0;
    clr_logs();
    start_addr = BASE;
    cmd(0);
    cmd(1);
    wait_quiet();
    chk("R9", "stop mid-chain active", q_active, 0);
    chk("R9", "stop mid-chain mover", mv_n, 1);
    chk("R9", "stop mid-chain cur", cur_addr, slot(1));

    // legacy transmit zero length, then bypass on resume
    @(negedge clk);
    mem[slot(0)[9:2]]     = mk_w0(1'b0, 1'b0, 20'h0, 4'h0, 8'h81);
    mem[slot(0)[9:2] + 2] = 32'(slot(1));
    mem[slot(0)[9:2] + 3] = mk_w3(1'b0, 1'b0, 20'h0, 4'h0, 1'b1);
    mem[slot(1)[9:2]]     = 32'h0;
    clr_logs();
    cmd(0);
    wait_quiet();
    chk("R8", "length error pulses", lerr_n, 1);
    chk("R8", "no mover on zero length", mv_n, 0);
    chk("R8", "parked on zero length", cur_addr, slot(0));
    chk("R8", "ownership kept", mem[slot(0)[9:2]][0], 1);
    @(negedge clk);
    mem[slot(0)[9:2]] = mem[slot(0)[9:2]] | 32'h4;
    cmd(2);
    wait_quiet();
    chk("R7", "bypass no mover", mv_n, 0);
    chk("R7", "bypass released", mem[slot(0)[9:2]][0], 0);
    chk("R7", "bypass word3 untouched", mem[slot(0)[9:2] + 3], mk_w3(1'b0, 1'b0, 20'h0, 4'h0, 1'b1));
    chk("R7", "bypass advances", cur_addr, slot(1));
    chk("R6", "bypass done pulse", done_n, 1);
    stop_check("R9");

    // extended transmit zero length goes to the mover
    @(negedge clk);
    mode_ext = 1'b1;
    mem[slot(0)[9:2]]     = mk_w0(1'b1, 1'b0, 20'h0, 4'h0, 8'h41);
    mem[slot(0)[9:2] + 3] = mk_w3(1'b1, 1'b0, 20'h0, 4'h0, 1'b0);
    clr_logs();
    cmd(0);
    wait_quiet();
    chk("R8", "ext zero length mover", mv_n, 1);
    chk("R8", "ext zero length len", mvl_len[0], 0);
    chk("R8", "ext zlp flag", mvl_zlp[0], 1);
    chk("R8", "ext no length error", lerr_n, 0);
    stop_check("R9");

    // receive directed cases in both layouts
    run_chain(1'b1, 1'b1, 3, 1'b0);
    stop_check("R9");
    run_chain(1'b0, 1'b1, 2, 1'b0);
    stop_check("R9");

    // random chains
    for (int it = 0; it < 12; it++) begin
      run_chain($urandom % 2, $urandom % 2, 1 + $urandom % 4, 1'b1);
      stop_check("R9");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule